// File: doc/BRIEF.md
# Power-Fail Gated Bank Chip-Enable Decoder

This block drives the active-low chip-enable lines of four external SRAM banks. Its inputs are one active-low chip-enable, a 2-bit bank select and a digitized sample of the supply level. While the supply is valid, the bank select is decoded and exactly one bank line follows the chip-enable input, one clock edge later. Every bank output comes straight from a flop, so a change of bank select cannot make two lines glitch low together.

When the supply sample drops below the active threshold, the block does not cut off an access that is already running. That access keeps its bank enabled until the chip-enable input returns high, or until a cycle-count timeout runs out, whichever comes first. After that, every bank line is held high. The lines stay high, whatever the chip-enable input does, until the supply is valid again.

A select pin chooses between two threshold levels. One suits a tight supply tolerance and the other a loose one. The same protected state is used from reset, so the banks are closed at power-up until the first valid supply sample.

Top module: `bank_ce_guard`

## Requirements
- R1: While reset is asserted, and at the first edge after it is released with an invalid supply, all four bank outputs `bankCeN` are high.
- R2: With the supply valid and the block running, the output `bankCeN[k]` whose index k equals `bankSel` (00 selects bit 0, 11 selects bit 3) takes the value of `ceN` one rising edge after it is sampled. All other outputs stay high.
- R3: At most one bit of `bankCeN` is low in any cycle, including across changes of `bankSel`.
- R4: A high `ceN` sampled at an edge leaves all bank outputs high after that edge.
- R5: The supply is valid when `supplyLvl` is at or above the threshold. With `thrSel` = 0 the threshold is `THR_HI`; with `thrSel` = 1 it is `THR_LO`. A sample exactly equal to the threshold counts as valid.
- R6: If `ceN` is low at the first edge that samples an invalid supply, the bank chosen at the last valid edge stays low. It goes high at the first edge that samples `ceN` high.
- R7: If `ceN` stays low after a power fail, the held bank is low after the first WAIT_MAX edges that sample the failed supply. All outputs are high from edge WAIT_MAX+1 onward.
- R8: Once the outputs are forced high, and while the supply stays invalid, a new low `ceN` opens no bank. A change of `bankSel` during a held access does not move the enabled bank.
- R9: When the supply becomes valid again, the outputs stay high after the first edge that samples it valid. Decoding resumes at the next edge.
- R10: A power fail sampled while `ceN` is high forces all outputs high at once, and they stay high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ceN | input | 1 | Chip-enable request, active low |
| bankSel | input | 2 | Bank select code |
| supplyLvl | input | 8 | Digitized supply level sample |
| thrSel | input | 1 | Threshold choice: 0 selects the higher level, 1 the lower |
| bankCeN | output | 4 | Conditioned bank chip-enables, active low |

## Verification
The bench builds the block with WAIT_MAX = 5 and keeps the default thresholds of 214 and 202. The short timeout lets a held access be followed edge by edge up to the forced cutoff, and past it, in a few cycles. Samples of 213, 202 and 201 sit right at the threshold boundaries. They show that the same sample is valid or invalid depending on `thrSel`, and that a sample equal to the threshold counts as valid.

// File: rtl/bank_guard_pkg.sv
package bank_guard_pkg;

  typedef enum logic [1:0] {
    GUARD_PROT  = 2'd0,
    GUARD_RUN   = 2'd1,
    GUARD_DRAIN = 2'd2
  } guardState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic live;  // decode bankSel and ceN this cycle
    logic hold;  // keep the latched bank enabled this cycle
  } ceStrobe_t;

endpackage

// File: rtl/bank_guard_ctrl.sv
module bank_guard_ctrl
  import bank_guard_pkg::*;
#(
  parameter int LVL_W    = 8,
  parameter int THR_HI   = 214,
  parameter int THR_LO   = 202,
  parameter int WAIT_MAX = 64,
  localparam int CNT_W   = (WAIT_MAX > 2) ? $clog2(WAIT_MAX) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic [LVL_W-1:0] supplyLvl,
  input  logic             thrSel,
  output ceStrobe_t        strobe
);

  localparam logic [LVL_W-1:0] LIM_HI  = LVL_W'(THR_HI);
  localparam logic [LVL_W-1:0] LIM_LO  = LVL_W'(THR_LO);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(WAIT_MAX - 1);

  guardState_t      state, stateNext;
  logic [CNT_W-1:0] waitCnt, waitCntNext;
  logic             powerOk;
  logic             timeUp;

  always_comb begin
    powerOk = supplyLvl >= (thrSel ? LIM_LO : LIM_HI);
    timeUp  = (waitCnt == CNT_END);
  end

  always_comb begin
    stateNext   = state;
    waitCntNext = waitCnt;
    strobe      = '0;
    unique case (state)
      GUARD_PROT: begin
        if (powerOk) stateNext = GUARD_RUN;
      end
      GUARD_RUN: begin
        if (powerOk) begin
          strobe.live = 1'b1;
        end else if (!ceN) begin
          strobe.hold = 1'b1;
          stateNext   = GUARD_DRAIN;
          waitCntNext = '0;
        end else begin
          stateNext = GUARD_PROT;
        end
      end
      GUARD_DRAIN: begin
        if (ceN || timeUp) begin
          stateNext = GUARD_PROT;
        end else begin
          strobe.hold = 1'b1;
          waitCntNext = waitCnt + 1'b1;
        end
      end
      default: stateNext = GUARD_PROT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= GUARD_PROT;
      waitCnt <= '0;
    end else begin
      state   <= stateNext;
      waitCnt <= waitCntNext;
    end
  end

endmodule

// File: rtl/bank_guard_dp.sv
module bank_guard_dp
  import bank_guard_pkg::*;
#(
  parameter int BANKS   = 4,
  localparam int SEL_W  = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic [SEL_W-1:0] bankSel,
  input  ceStrobe_t        strobe,
  output logic [BANKS-1:0] bankCeN
);

  logic [SEL_W-1:0] heldBank;
  logic [BANKS-1:0] ceNext;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_comb begin
      ceNext[b] = !((strobe.live && !ceN && (bankSel == SEL_W'(b))) ||
                    (strobe.hold && (heldBank == SEL_W'(b))));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankCeN  <= '1;
      heldBank <= '0;
    end else begin
      bankCeN <= ceNext;
      if (strobe.live) heldBank <= bankSel;
    end
  end

endmodule

// File: rtl/bank_ce_guard.sv
module bank_ce_guard
  import bank_guard_pkg::*;
#(
  parameter int BANKS    = 4,
  parameter int LVL_W    = 8,
  parameter int THR_HI   = 214,
  parameter int THR_LO   = 202,
  parameter int WAIT_MAX = 64,
  localparam int SEL_W   = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic [SEL_W-1:0] bankSel,
  input  logic [LVL_W-1:0] supplyLvl,
  input  logic             thrSel,
  output logic [BANKS-1:0] bankCeN
);

  ceStrobe_t strobe;

  bank_guard_ctrl #(
    .LVL_W(LVL_W), .THR_HI(THR_HI), .THR_LO(THR_LO), .WAIT_MAX(WAIT_MAX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .supplyLvl(supplyLvl),
    .thrSel(thrSel), .strobe(strobe)
  );

  bank_guard_dp #(.BANKS(BANKS)) u_dp (
    .clk(clk), .rstN(rstN), .ceN(ceN), .bankSel(bankSel),
    .strobe(strobe), .bankCeN(bankCeN)
  );

endmodule

// File: rtl/bank_ce_guard_chk.sv
module bank_ce_guard_chk #(
  parameter int BANKS    = 4,
  parameter int LVL_W    = 8,
  parameter int THR_HI   = 214,
  parameter int THR_LO   = 202,
  parameter int WAIT_MAX = 64,
  localparam int LEN_W   = $clog2(WAIT_MAX + 2) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             ceN,
  input logic [LVL_W-1:0] supplyLvl,
  input logic             thrSel,
  input logic [BANKS-1:0] bankCeN
);

  logic             okNow;
  logic             prevBad;
  logic [LEN_W-1:0] badLen;

  always_comb okNow = supplyLvl >= (thrSel ? LVL_W'(THR_LO) : LVL_W'(THR_HI));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBad <= 1'b0;
      badLen  <= '0;
    end else begin
      prevBad <= !okNow;
      if (okNow) badLen <= '0;
      else if (badLen <= LEN_W'(WAIT_MAX)) badLen <= badLen + 1'b1;
    end
  end

  // R3
  one_bank_max_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~bankCeN));

  // R4
  idle_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> &bankCeN);

  // R7
  timeout_cut_chk: assert property (@(posedge clk) disable iff (!rstN)
    (badLen > LEN_W'(WAIT_MAX)) |-> &bankCeN);

  // R8
  latched_prot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prevBad && !okNow && &bankCeN) |=> &bankCeN);

endmodule

bind bank_ce_guard bank_ce_guard_chk #(
  .BANKS(BANKS), .LVL_W(LVL_W), .THR_HI(THR_HI), .THR_LO(THR_LO),
  .WAIT_MAX(WAIT_MAX)
) u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .supplyLvl(supplyLvl),
  .thrSel(thrSel), .bankCeN(bankCeN)
);

// File: tb/bank_ce_guard_tb.sv
`timescale 1ns/100ps
module bank_ce_guard_tb;

  localparam int W = 5;

  logic       clk = 1'b0;
  logic       rstN;
  logic       ceN;
  logic [1:0] bankSel;
  logic [7:0] supplyLvl;
  logic       thrSel;
  logic [3:0] bankCeN;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bank_ce_guard #(.WAIT_MAX(W)) u_dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .bankSel(bankSel),
    .supplyLvl(supplyLvl), .thrSel(thrSel), .bankCeN(bankCeN)
  );

  task automatic chk(input logic [3:0] exp, input string req);
    checks++;
    if (bankCeN !== exp) begin
      errors++;
      $display("FAIL %s bankCeN=%b expected=%b", req, bankCeN, exp);
    end
  endtask

  // inputs change on the falling edge; step samples just after the rise
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic c, input logic [1:0] s,
                       input logic [7:0] lvl, input logic t);
    @(negedge clk);
    ceN = c; bankSel = s; supplyLvl = lvl; thrSel = t;
  endtask

  task automatic test_reset();
    rstN = 1'b0; ceN = 1'b0; bankSel = 2'd0; supplyLvl = 8'd0; thrSel = 1'b0;
    repeat (3) step();
    chk(4'b1111, "R1 in reset");
    @(negedge clk); rstN = 1'b1;
    step();
    chk(4'b1111, "R1 after release, supply invalid");
  endtask

  task automatic test_powerup();
    drive(1'b0, 2'd1, 8'd230, 1'b0);
    step(); chk(4'b1111, "R9 first valid edge");
    step(); chk(4'b1101, "R9 decode resumes");
  endtask

  task automatic test_decode();
    for (int s = 0; s < 4; s++) begin
      drive(1'b0, 2'(s), 8'd230, 1'b0);
      step(); chk(~(4'b0001 << s), "R2 bank decode");
    end
    drive(1'b1, 2'd2, 8'd230, 1'b0);
    step(); chk(4'b1111, "R4 ceN high closes all");
    drive(1'b0, 2'd0, 8'd230, 1'b0);
    step(); chk(4'b1110, "R3 single bank");
    drive(1'b0, 2'd3, 8'd230, 1'b0);
    step(); chk(4'b0111, "R3 switch to bank 3");
  endtask

  task automatic test_threshold();
    drive(1'b1, 2'd1, 8'd213, 1'b0);
    step(); chk(4'b1111, "R10 fail with ceN high");
    drive(1'b0, 2'd1, 8'd213, 1'b0);
    step(); chk(4'b1111, "R5 213 invalid on high threshold");
    step(); chk(4'b1111, "R8 ceN low stays closed");
    drive(1'b0, 2'd1, 8'd213, 1'b1);
    step(); chk(4'b1111, "R9 valid on low threshold, first edge");
    step(); chk(4'b1101, "R5 213 valid on low threshold");
    drive(1'b1, 2'd1, 8'd201, 1'b1);
    step(); chk(4'b1111, "R10 201 below low threshold");
    drive(1'b0, 2'd1, 8'd202, 1'b1);
    step(); chk(4'b1111, "R9 202 equal threshold, first edge");
    step(); chk(4'b1101, "R5 202 equal threshold is valid");
  endtask

  task automatic test_drain();
    drive(1'b0, 2'd2, 8'd230, 1'b0);
    step(); chk(4'b1011, "R2 bank 2 open");
    drive(1'b0, 2'd2, 8'd100, 1'b0);
    step(); chk(4'b1011, "R6 access held after fail");
    drive(1'b0, 2'd0, 8'd100, 1'b0);
    step(); chk(4'b1011, "R8 bank select ignored while held");
    drive(1'b1, 2'd0, 8'd100, 1'b0);
    step(); chk(4'b1111, "R6 access ends on ceN high");
    drive(1'b0, 2'd0, 8'd100, 1'b0);
    step(); chk(4'b1111, "R8 new ceN does not reopen");
    step(); chk(4'b1111, "R8 still closed");
    drive(1'b0, 2'd0, 8'd230, 1'b0);
    step(); chk(4'b1111, "R9 restore, first edge");
    step(); chk(4'b1110, "R9 restore, decode bank 0");
  endtask

  task automatic test_timeout();
    drive(1'b0, 2'd3, 8'd230, 1'b0);
    step(); chk(4'b0111, "R2 bank 3 open");
    drive(1'b0, 2'd3, 8'd50, 1'b0);
    for (int k = 1; k <= W; k++) begin
      step(); chk(4'b0111, "R7 held within window");
    end
    step(); chk(4'b1111, "R7 forced high at timeout");
    step(); chk(4'b1111, "R7 stays high after timeout");
    drive(1'b0, 2'd3, 8'd230, 1'b0);
    step(); chk(4'b1111, "R9 restore after timeout");
    step(); chk(4'b0111, "R9 decode after timeout");
  endtask

  initial begin
    test_reset();
    test_powerup();
    test_decode();
    test_threshold();
    test_drain();
    test_timeout();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule